// File: doc/BRIEF.md
# Memory Fault Status Recorder

This block records the fault that address translation reports, so that privileged software can read it back later. One or more fault sources present a strobe, a base fault kind, a flag that marks a page-level access rather than a section, a 4-bit domain number and the 32-bit virtual address. The block turns the kind and the flag into a final 4-bit fault code and puts that code together with the domain into an 8-bit status value. It latches the status and the faulting address in two registers. Both registers are read-only: the block has no write path into them.

Each cycle the lowest-numbered source that carries a meaningful fault wins, and the other sources in that cycle are dropped. A clear input zeroes both registers. A fault that arrives in the same cycle as a clear is still recorded. The translation walk, the permission checks and the exception entry that follow a fault are outside this block.

Top module: `mfsr_recorder`

## Requirements
- R1: While `rst_n` is low, at each rising clock edge both `status_o` and `addr_o` become zero.
- R2: For a source with its page flag set and a base kind of 4, 5, 8, 9 or 0xD, the recorded code in `status_o[3:0]` is the kind with bit 1 set: 6, 7, 0xA, 0xB or 0xF.
- R3: For any other recordable kind (1, 3, 6, 7, 0xA, 0xB, 0xC, 0xE, 0xF), and for every kind when the page flag is clear, the recorded code equals the base kind. Kind 3 marks a bus error that did not come from translation.
- R4: `status_o[7:4]` holds the domain number of the recorded fault, and `status_o[3:0]` holds its code.
- R5: `addr_o` holds the 32-bit virtual address of the recorded fault. Both registers update one clock after the strobe.
- R6: A strobe with kind 0 (no fault) or kind 2 (never produced) records nothing. A source whose strobe is low records nothing, whatever its other inputs are. In both cases both registers keep their values.
- R7: When several sources present a recordable fault in one cycle, only the lowest-indexed of them is recorded. Source 0 has the highest priority.
- R8: A clear with no recordable fault in the same cycle sets both registers to zero.
- R9: A recordable fault in the same cycle as a clear is recorded, and the clear has no effect in that cycle.
- R10: With no recordable fault and no clear, both registers hold their values. The recorded code is never 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| clr | input | 1 | Zero both registers |
| flt_valid | input | NSRC | Per-source fault strobe |
| flt_kind | input | 4*NSRC | Per-source base fault kind |
| flt_page | input | NSRC | Per-source page-level flag |
| flt_domain | input | DOM_W*NSRC | Per-source domain number |
| flt_vaddr | input | ADDR_W*NSRC | Per-source faulting virtual address |
| status_o | output | DOM_W+4 | Recorded domain and fault code |
| addr_o | output | ADDR_W | Recorded faulting address |

## Verification
The assertions assume that every input is driven to a known value once reset has been released. They also assume that a source's kind, page flag, domain and address are meaningful only while that source's strobe is high. The priority and address checks relate the registers to source 0 only, on the basis that a recordable fault on source 0 must always win. The stimulus changes inputs only on the falling edge and holds them through the next rising edge. It pairs valid strobes with every kind value of interest and deliberately drives strobes with kinds 0 and 2 to exercise the ignore rules.

// File: rtl/mfsr_pkg.sv
package mfsr_pkg;

    localparam int CODE_W = 4;

    localparam logic [CODE_W-1:0] KIND_NONE     = 4'h0;
    localparam logic [CODE_W-1:0] KIND_RESERVED = 4'h2;
    localparam logic [CODE_W-1:0] PAGE_BIT_MASK = 4'h2;

    // Kinds whose page variant is formed by setting bit 1
    function automatic logic has_page_form(input logic [CODE_W-1:0] kind);
        return (kind == 4'h4) || (kind == 4'h5) || (kind == 4'h8) ||
               (kind == 4'h9) || (kind == 4'hD);
    endfunction

    // A strobe carrying this kind produces a record
    function automatic logic is_recordable(input logic [CODE_W-1:0] kind);
        return (kind != KIND_NONE) && (kind != KIND_RESERVED);
    endfunction

endpackage

// File: rtl/mfsr_encode.sv
module mfsr_encode
    import mfsr_pkg::*;
#(
    parameter int NSRC = 3
) (
    input  logic [NSRC-1:0]        valid_i,
    input  logic [NSRC*CODE_W-1:0] kind_i,
    input  logic [NSRC-1:0]        page_i,
    output logic [NSRC*CODE_W-1:0] code_o,
    output logic [NSRC-1:0]        live_o
);

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        logic [CODE_W-1:0] kind_s;
        assign kind_s = kind_i[s*CODE_W +: CODE_W];

        always_comb begin
            code_o[s*CODE_W +: CODE_W] = kind_s;
            if (page_i[s] && has_page_form(kind_s))
                code_o[s*CODE_W +: CODE_W] = kind_s | PAGE_BIT_MASK;
            live_o[s] = valid_i[s] && is_recordable(kind_s);
        end
    end

endmodule

// File: rtl/mfsr_pick.sv
module mfsr_pick #(
    parameter int NSRC  = 3,
    parameter int REC_W = 40
) (
    input  logic [NSRC-1:0]       live_i,
    input  logic [NSRC*REC_W-1:0] rec_i,
    output logic                  hit_o,
    output logic [REC_W-1:0]      rec_o
);

    always_comb begin
        hit_o = 1'b0;
        rec_o = '0;
        // walk from the lowest priority up so source 0 overwrites last
        for (int s = NSRC - 1; s >= 0; s--) begin
            if (live_i[s]) begin
                hit_o = 1'b1;
                rec_o = rec_i[s*REC_W +: REC_W];
            end
        end
    end

endmodule

// File: rtl/mfsr_recorder.sv
module mfsr_recorder
    import mfsr_pkg::*;
#(
    parameter int NSRC   = 3,
    parameter int DOM_W  = 4,
    parameter int ADDR_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic [NSRC-1:0]         flt_valid,
    input  logic [NSRC*CODE_W-1:0]  flt_kind,
    input  logic [NSRC-1:0]         flt_page,
    input  logic [NSRC*DOM_W-1:0]   flt_domain,
    input  logic [NSRC*ADDR_W-1:0]  flt_vaddr,
    output logic [DOM_W+CODE_W-1:0] status_o,
    output logic [ADDR_W-1:0]       addr_o
);

    localparam int STAT_W = DOM_W + CODE_W;
    localparam int REC_W  = STAT_W + ADDR_W;

    typedef struct packed {
        logic [STAT_W-1:0] stat;
        logic [ADDR_W-1:0] addr;
    } rec_t;

    logic [NSRC*CODE_W-1:0] code_w;
    logic [NSRC-1:0]        live_w;
    logic [NSRC*REC_W-1:0]  recs_w;
    logic                   hit_w;
    logic [REC_W-1:0]       pick_w;

    rec_t rec_d, rec_q;

    mfsr_encode #(.NSRC(NSRC)) u_encode (
        .valid_i (flt_valid),
        .kind_i  (flt_kind),
        .page_i  (flt_page),
        .code_o  (code_w),
        .live_o  (live_w)
    );

    for (genvar s = 0; s < NSRC; s++) begin : g_rec
        assign recs_w[s*REC_W +: REC_W] = {flt_domain[s*DOM_W +: DOM_W],
                                           code_w[s*CODE_W +: CODE_W],
                                           flt_vaddr[s*ADDR_W +: ADDR_W]};
    end

    mfsr_pick #(.NSRC(NSRC), .REC_W(REC_W)) u_pick (
        .live_i (live_w),
        .rec_i  (recs_w),
        .hit_o  (hit_w),
        .rec_o  (pick_w)
    );

    always_comb begin
        rec_d = rec_q;
        if (hit_w)
            rec_d = rec_t'(pick_w);
        else if (clr)
            rec_d = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            rec_q <= '0;
        else
            rec_q <= rec_d;
    end

    assign status_o = rec_q.stat;
    assign addr_o   = rec_q.addr;

    // Source-0 view and an independent "anything recordable" flag
    logic [CODE_W-1:0] kind0_w;
    logic              live0_w;
    logic              any_live_w;
    assign kind0_w = flt_kind[CODE_W-1:0];
    assign live0_w = flt_valid[0] && (kind0_w != 4'h0) && (kind0_w != 4'h2);
    always_comb begin
        any_live_w = 1'b0;
        for (int s = 0; s < NSRC; s++)
            if (flt_valid[s] && (flt_kind[s*CODE_W +: CODE_W] != 4'h0) &&
                (flt_kind[s*CODE_W +: CODE_W] != 4'h2))
                any_live_w = 1'b1;
    end

    AST_RESET_ZERO: assert property (@(posedge clk)
        !rst_n |=> (status_o == '0 && addr_o == '0)); // R1

    AST_PAGE_FORM: assert property (@(posedge clk) disable iff (!rst_n)
        (live0_w && flt_page[0] && (kind0_w == 4'h5 || kind0_w == 4'h9))
        |=> status_o[1]); // R2

    AST_DOMAIN_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        live0_w |=> status_o[STAT_W-1:CODE_W] == $past(flt_domain[DOM_W-1:0])); // R4

    AST_SRC0_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        live0_w |=> addr_o == $past(flt_vaddr[ADDR_W-1:0])); // R7

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !any_live_w) |=> (status_o == '0 && addr_o == '0)); // R8

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !any_live_w) |=> ($stable(status_o) && $stable(addr_o))); // R10

    AST_NO_CODE2: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[CODE_W-1:0] != 4'h2); // R10

endmodule

// File: tb/mfsr_recorder_test.sv
module mfsr_recorder_test;

    localparam int NSRC = 3;
    localparam int DW   = 4;
    localparam int AW   = 32;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               clr = 1'b0;
    logic [NSRC-1:0]    flt_valid = '0;
    logic [NSRC*4-1:0]  flt_kind = '0;
    logic [NSRC-1:0]    flt_page = '0;
    logic [NSRC*DW-1:0] flt_domain = '0;
    logic [NSRC*AW-1:0] flt_vaddr = '0;
    logic [DW+3:0]      status_o;
    logic [AW-1:0]      addr_o;

    // pending source values, applied by the driver on the next step
    logic [NSRC-1:0]    pv = '0;
    logic [NSRC*4-1:0]  pk = '0;
    logic [NSRC-1:0]    pp = '0;
    logic [NSRC*DW-1:0] pd = '0;
    logic [NSRC*AW-1:0] pa = '0;

    logic [7:0]  exp_stat = '0;
    logic [31:0] exp_addr = '0;

    logic [39:0] q_exp[$];
    string       q_tag[$];

    int tests = 0;
    int failed = 0;
    bit done = 0;

    mfsr_recorder #(.NSRC(NSRC), .DOM_W(DW), .ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .flt_valid(flt_valid),
        .flt_kind(flt_kind), .flt_page(flt_page), .flt_domain(flt_domain),
        .flt_vaddr(flt_vaddr), .status_o(status_o), .addr_o(addr_o)
    );

    always #5 clk = ~clk;

    function automatic logic [3:0] model_code(input logic [3:0] k, input logic pg);
        if (pg && (k == 4'h4 || k == 4'h5 || k == 4'h8 || k == 4'h9 || k == 4'hD))
            return k | 4'h2;
        return k;
    endfunction

    task automatic set_src(input int s, input logic [3:0] k, input logic pg,
                           input logic [3:0] d, input logic [31:0] a);
        pv[s] = 1'b1;
        pk[s*4 +: 4] = k;
        pp[s] = pg;
        pd[s*DW +: DW] = d;
        pa[s*AW +: AW] = a;
    endtask

    // driver: apply one cycle of stimulus and push the expected result
    task automatic step(input logic rst, input logic c, input string tag);
        bit found;
        @(negedge clk);
        rst_n = ~rst;
        clr = c;
        flt_valid = pv; flt_kind = pk; flt_page = pp;
        flt_domain = pd; flt_vaddr = pa;
        found = 0;
        if (rst) begin
            exp_stat = '0; exp_addr = '0;
        end else begin
            for (int s = 0; s < NSRC; s++) begin
                if (!found && pv[s] && pk[s*4 +: 4] != 4'h0 && pk[s*4 +: 4] != 4'h2) begin
                    found = 1;
                    exp_stat = {pd[s*DW +: DW], model_code(pk[s*4 +: 4], pp[s])};
                    exp_addr = pa[s*AW +: AW];
                end
            end
            if (!found && c) begin
                exp_stat = '0; exp_addr = '0;
            end
        end
        q_exp.push_back({exp_stat, exp_addr});
        q_tag.push_back(tag);
        pv = '0; pk = '0; pp = '0; pd = '0; pa = '0;
    endtask

    // monitor: compare just after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q_exp.size() > 0) begin
                logic [39:0] e;
                string t;
                e = q_exp.pop_front();
                t = q_tag.pop_front();
                tests++;
                if ({status_o, addr_o} !== e) begin
                    failed++;
                    $display("FAIL %s: status=%h addr=%h expected status=%h addr=%h",
                             t, status_o, addr_o, e[39:32], e[31:0]);
                end
            end
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            tests++;
            failed++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, failed);
            $finish;
        end
    end

    initial begin
        step(1, 0, "R1 reset");
        step(1, 0, "R1 reset");
        step(0, 0, "R10 idle after reset");
        // section fault, domain and address captured
        set_src(0, 4'h5, 0, 4'h3, 32'h1234_5678);
        step(0, 0, "R4 R5 section translation");
        step(0, 0, "R10 hold");
        // strobe low with junk on other inputs
        set_src(0, 4'h9, 1, 4'hE, 32'hDEAD_0000); pv[0] = 1'b0;
        step(0, 0, "R6 strobe low ignored");
        // page forms
        set_src(0, 4'h5, 1, 4'h1, 32'h0000_1000); step(0, 0, "R2 page translation 7");
        set_src(0, 4'h8, 1, 4'h2, 32'h0000_2000); step(0, 0, "R2 page bus error A");
        set_src(0, 4'hD, 1, 4'h7, 32'h0000_3000); step(0, 0, "R2 page permission F");
        set_src(0, 4'h4, 1, 4'hF, 32'hFFFF_FFFC); step(0, 0, "R2 page linefetch 6");
        set_src(0, 4'h9, 1, 4'h0, 32'h0000_4000); step(0, 0, "R2 page domain B");
        // kinds passed through unchanged
        set_src(0, 4'h1, 1, 4'h4, 32'h0000_0003); step(0, 0, "R3 alignment with page flag");
        set_src(0, 4'hC, 1, 4'h5, 32'h0000_5000); step(0, 0, "R3 level-1 error with page flag");
        set_src(0, 4'h3, 1, 4'h6, 32'h0000_6000); step(0, 0, "R3 non-translation bus error");
        set_src(0, 4'hE, 0, 4'h8, 32'h0000_7000); step(0, 0, "R3 level-2 error");
        set_src(0, 4'hD, 0, 4'h9, 32'h0000_8000); step(0, 0, "R3 section permission D");
        // ignored kinds
        set_src(0, 4'h0, 1, 4'hA, 32'hAAAA_AAAA); step(0, 0, "R6 kind 0 ignored");
        set_src(0, 4'h2, 0, 4'hB, 32'hBBBB_BBBB); step(0, 0, "R6 kind 2 ignored");
        // priority
        set_src(1, 4'h5, 0, 4'h1, 32'h1111_0000);
        set_src(2, 4'h8, 0, 4'h2, 32'h2222_0000);
        step(0, 0, "R7 source 1 over source 2");
        set_src(0, 4'h0, 0, 4'h3, 32'h3333_0000);
        set_src(2, 4'h9, 1, 4'h4, 32'h4444_0000);
        step(0, 0, "R7 source 0 kind 0 loses to source 2");
        set_src(0, 4'h4, 0, 4'h5, 32'h5555_0000);
        set_src(1, 4'h5, 1, 4'h6, 32'h6666_0000);
        set_src(2, 4'hD, 1, 4'h7, 32'h7777_0000);
        step(0, 0, "R7 source 0 wins");
        // clear
        step(0, 1, "R8 clear");
        step(0, 0, "R10 hold after clear");
        set_src(1, 4'hB, 0, 4'hC, 32'h8888_0000);
        step(0, 1, "R9 fault beats clear");
        set_src(0, 4'h2, 0, 4'h1, 32'h9999_0000);
        step(0, 1, "R8 clear with only kind 2");
        // reset mid-run
        set_src(0, 4'h7, 0, 4'h2, 32'hCAFE_0000); step(0, 0, "R3 page translation passed");
        set_src(0, 4'h5, 0, 4'h2, 32'hCAFE_1000); step(1, 0, "R1 reset overrides fault");
        step(0, 0, "R10 idle");
        step(0, 0, "R10 idle");
        while (q_exp.size() > 0) @(posedge clk);
        #2;
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end

endmodule